// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block holds a muxed-D scan chain of configurable length around a small combinational core. It also contains the controller that runs a complete scan test on that chain. The controller drives the chain's mode select, its serial input and its clock enable. A single start pulse runs two phases in a fixed order.

The first phase is a flush of the chain. A repeating two-zeros, two-ones pattern is shifted through the chain, and the serial output is checked against the serial input delayed by the chain length.

The second phase applies a table of combinational vectors held in registers inside the block. Each vector is shifted in and captured in one normal-mode clock. Its response is then shifted out while the next vector is shifted in. The primary outputs are compared during capture, and the next-state bits are compared as they leave the chain.

The first mismatch latches a sticky fail flag and the index of the active clock on which it occurred. A cycle counter ends at the closed-form test length, and a done pulse marks the end of the run. The vector table is written through a simple write port while the controller is idle.

Top module: `scan_seq_top`

## Requirements
- R1: After reset: tc_o=1, clk_en_o=0, done_o=0, fail_o=0, cyc_cnt_o=0, sin_o=0, sout_o=0. All chain flops are reset to 0.
- R2: A start_i pulse while idle begins a run. clk_en_o is high from the next cycle, and cyc_cnt_o counts the active clocks from 0 (equal to k in active cycle k). A start_i pulse while a run is in progress has no effect.
- R3: The flush phase lasts NSFF+4 active cycles with tc_o=0 (scan mode, where each flop takes its serial predecessor). In flush cycle k, sin_o equals bit 1 of k, which gives the sequence 0,0,1,1,0,0,1,1,...
- R4: In flush cycle k, for k>=NSFF, sout_o must equal the sin_o of flush cycle k-NSFF; any other value is a mismatch. sout_o is the last flop of the chain, and sin_o enters flop 0.
- R5: Each vector v takes NSFF shift cycles with tc_o=0, followed by exactly one capture cycle with tc_o=1. In shift cycle b, sin_o = ps[v][NSFF-1-b], so the most significant present-state bit goes first. The primary inputs are held at pi[v].
- R6: The core computes ns[i] = s[i] ^ s[(i+1) mod NSFF] ^ pi[i mod NPI] and po[j] = s[j mod NSFF] & pi[j mod NPI]. The capture loads ns into the chain.
- R7: In shift cycle b after a capture, sout_o = captured ns[NSFF-1-b]. After the last capture, NSFF unload cycles with tc_o=0 follow; sin_o is don't-care during them.
- R8: A mismatch of po against the expected po during capture, or of the unloaded bits against the expected ns, is an error, as is a flush error (R4). The first error sets fail_o, which stays set, and loads fail_cyc_o with that cycle's cyc_cnt_o value. Both are cleared when the next run starts.
- R9: After the last unload clock, done_o pulses for one cycle while clk_en_o is low. cyc_cnt_o then equals (NCOMB+2)*NSFF+NCOMB+4 and holds until the next start.
- R10: A table write (wr_en_i with index, pi, ps, expected po and ns) is accepted only while idle. Writes during a run are ignored.
- R11: While idle, tc_o=1 (normal mode) and clk_en_o=0, so the chain holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| wr_en_i | input | 1 | Vector table write enable |
| wr_idx_i | input | IW | Vector table entry index |
| wr_pi_i | input | NPI | Primary input value of the entry |
| wr_ps_i | input | NSFF | Present-state bits of the entry |
| wr_po_i | input | NPO | Expected primary outputs |
| wr_ns_i | input | NSFF | Expected next-state bits |
| tc_o | output | 1 | Chain mode: 0 scan, 1 normal |
| sin_o | output | 1 | Serial input driven into the chain |
| sout_o | output | 1 | Serial output of the chain |
| clk_en_o | output | 1 | Chain clock enable, high during a run |
| done_o | output | 1 | End-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_cyc_o | output | CW | Active-cycle index of the first mismatch |
| cyc_cnt_o | output | CW | Active clock count |

## Verification
The bench models the chain bit by bit. It checks tc_o, sin_o and sout_o on every active cycle, so a shift order that is reversed or an unload shifted by one cycle shows up as a sout_o error. Expected entries are corrupted one at a time so that the run fails at a known cycle: a capture cycle (22), and an early unload bit before a later one (13, not 31). A design that recorded the last error, or that was off by one in the cycle index, reports the wrong value. A start pulse and a table write arrive mid-run; a design that restarted or accepted the write would break the cycle count or fail a clean run. The final count must match the closed-form length exactly.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_FLUSH, PH_SHIFT, PH_CAPT, PH_UNLD
  } phase_e;
endpackage

// File: rtl/scan_core.sv
module scan_core #(
  parameter int NSFF = 4,
  parameter int NPI  = 2,
  parameter int NPO  = 2
) (
  input  logic [NSFF-1:0] ps_i,
  input  logic [NPI-1:0]  pi_i,
  output logic [NSFF-1:0] ns_o,
  output logic [NPO-1:0]  po_o
);
  for (genvar i = 0; i < NSFF; i++) begin : g_ns
    assign ns_o[i] = ps_i[i] ^ ps_i[(i+1) % NSFF] ^ pi_i[i % NPI];
  end
  for (genvar j = 0; j < NPO; j++) begin : g_po
    assign po_o[j] = ps_i[j % NSFF] & pi_i[j % NPI];
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int NSFF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tc_i,
  input  logic            sin_i,
  input  logic [NSFF-1:0] d_i,
  output logic [NSFF-1:0] q_o,
  output logic            sout_o
);
  for (genvar i = 0; i < NSFF; i++) begin : g_sff
    logic ser;
    if (i == 0) begin : g_head
      assign ser = sin_i;
    end else begin : g_body
      assign ser = q_o[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[i] <= 1'b0;
      else if (en_i) q_o[i] <= tc_i ? d_i[i] : ser;
    end
  end
  assign sout_o = q_o[NSFF-1];
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 4,
  parameter int NCOMB = 4,
  parameter int BW    = 3,
  parameter int VW    = 3,
  parameter int CW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [BW-1:0] bit_o,
  output logic [VW-1:0] vec_o,
  output logic [CW-1:0] cyc_o,
  output logic          done_o
);
  phase_e        ph_q;
  logic [BW-1:0] bit_q;
  logic [VW-1:0] vec_q;
  logic [CW-1:0] cyc_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      vec_q  <= '0;
      cyc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ph_q != PH_IDLE) cyc_q <= cyc_q + 1'b1;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_FLUSH;
          bit_q <= '0;
          vec_q <= '0;
          cyc_q <= '0;
        end
        PH_FLUSH: begin
          if (bit_q == BW'(NSFF + 3)) begin
            ph_q  <= PH_SHIFT;
            bit_q <= '0;
          end else bit_q <= bit_q + 1'b1;
        end
        PH_SHIFT: begin
          if (bit_q == BW'(NSFF - 1)) begin
            ph_q  <= PH_CAPT;
            bit_q <= '0;
          end else bit_q <= bit_q + 1'b1;
        end
        PH_CAPT: begin
          vec_q <= vec_q + 1'b1;
          ph_q  <= (vec_q == VW'(NCOMB - 1)) ? PH_UNLD : PH_SHIFT;
        end
        PH_UNLD: begin
          if (bit_q == BW'(NSFF - 1)) begin
            ph_q   <= PH_IDLE;
            bit_q  <= '0;
            done_q <= 1'b1;
          end else bit_q <= bit_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
  assign bit_o   = bit_q;
  assign vec_o   = vec_q;
  assign cyc_o   = cyc_q;
  assign done_o  = done_q;
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 4,
  parameter int NPI   = 2,
  parameter int NPO   = 2,
  parameter int NCOMB = 4,
  localparam int TOTAL = (NCOMB + 2) * NSFF + NCOMB + 4,
  localparam int IW    = $clog2(NCOMB),
  localparam int CW    = $clog2(TOTAL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [NPI-1:0]  wr_pi_i,
  input  logic [NSFF-1:0] wr_ps_i,
  input  logic [NPO-1:0]  wr_po_i,
  input  logic [NSFF-1:0] wr_ns_i,
  output logic            tc_o,
  output logic            sin_o,
  output logic            sout_o,
  output logic            clk_en_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [CW-1:0]   fail_cyc_o,
  output logic [CW-1:0]   cyc_cnt_o
);
  localparam int BW = $clog2(NSFF + 4);
  localparam int VW = $clog2(NCOMB + 1);
  localparam int SW = (NSFF > 1) ? $clog2(NSFF) : 1;

  phase_e        ph;
  logic [BW-1:0] bit_c;
  logic [VW-1:0] vec_c;
  logic [CW-1:0] cyc_c;
  logic [BW-1:0] fl_ref;
  logic [SW-1:0] sidx;
  logic [IW-1:0] cur, prev;
  logic [NSFF-1:0] chain_q, core_ns;
  logic [NPI-1:0]  core_pi;
  logic [NPO-1:0]  core_po;
  logic            mis, fail_q;
  logic [CW-1:0]   fcyc_q;

  logic [NPI-1:0]  tab_pi [NCOMB];
  logic [NSFF-1:0] tab_ps [NCOMB];
  logic [NPO-1:0]  tab_po [NCOMB];
  logic [NSFF-1:0] tab_ns [NCOMB];

  scan_seq_ctrl #(.NSFF(NSFF), .NCOMB(NCOMB), .BW(BW), .VW(VW), .CW(CW)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .phase_o(ph), .bit_o(bit_c), .vec_o(vec_c), .cyc_o(cyc_c), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < NCOMB; v++) begin
        tab_pi[v] <= '0;
        tab_ps[v] <= '0;
        tab_po[v] <= '0;
        tab_ns[v] <= '0;
      end
    end else if (wr_en_i && ph == PH_IDLE) begin
      tab_pi[wr_idx_i] <= wr_pi_i;
      tab_ps[wr_idx_i] <= wr_ps_i;
      tab_po[wr_idx_i] <= wr_po_i;
      tab_ns[wr_idx_i] <= wr_ns_i;
    end
  end

  assign cur     = IW'(vec_c);
  assign prev    = IW'(vec_c - 1'b1);
  assign sidx    = SW'(NSFF - 1) - SW'(bit_c);
  assign fl_ref  = bit_c - BW'(NSFF);
  assign core_pi = (ph == PH_UNLD) ? '0 : tab_pi[cur];

  assign clk_en_o = (ph != PH_IDLE);
  assign tc_o     = (ph == PH_IDLE) || (ph == PH_CAPT);

  always_comb begin
    unique case (ph)
      PH_FLUSH: sin_o = bit_c[1];
      PH_SHIFT: sin_o = tab_ps[cur][sidx];
      default:  sin_o = 1'b0;
    endcase
  end

  scan_core #(.NSFF(NSFF), .NPI(NPI), .NPO(NPO)) core_i (
    .ps_i(chain_q), .pi_i(core_pi), .ns_o(core_ns), .po_o(core_po)
  );

  scan_chain #(.NSFF(NSFF)) chain_i (
    .clk_i, .rst_ni, .en_i(clk_en_o), .tc_i(tc_o), .sin_i(sin_o),
    .d_i(core_ns), .q_o(chain_q), .sout_o(sout_o)
  );

  always_comb begin
    unique case (ph)
      PH_FLUSH: mis = (bit_c >= BW'(NSFF)) && (sout_o != fl_ref[1]);
      PH_SHIFT: mis = (vec_c != '0) && (sout_o != tab_ns[prev][sidx]);
      PH_CAPT:  mis = (core_po != tab_po[cur]);
      PH_UNLD:  mis = (sout_o != tab_ns[prev][sidx]);
      default:  mis = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      fcyc_q <= '0;
    end else if (ph == PH_IDLE && start_i) begin
      fail_q <= 1'b0;
      fcyc_q <= '0;
    end else if (mis && !fail_q) begin
      fail_q <= 1'b1;
      fcyc_q <= cyc_c;
    end
  end

  assign fail_o     = fail_q;
  assign fail_cyc_o = fcyc_q;
  assign cyc_cnt_o  = cyc_c;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CW    = 6,
  parameter int TOTAL = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          tc_o,
  input logic          clk_en_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [CW-1:0] cyc_cnt_o
);
  assert_idle_normal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> tc_o);
  assert_capture_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && tc_o) |=> !tc_o);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> (!clk_en_o || cyc_cnt_o == CW'($past(cyc_cnt_o) + 1'b1)));
  assert_start_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> cyc_cnt_o == '0);
  assert_end_total_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> (done_o && cyc_cnt_o == CW'(TOTAL)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !(start_i && !clk_en_o)) |=> fail_o);
endmodule

bind scan_seq_top scan_seq_chk #(.CW(CW), .TOTAL(TOTAL)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tc_o(tc_o),
  .clk_en_o(clk_en_o), .done_o(done_o), .fail_o(fail_o), .cyc_cnt_o(cyc_cnt_o)
);

// File: tb/scan_seq_top_tb_top.sv
module scan_seq_top_tb_top;
  localparam int NSFF  = 4;
  localparam int NPI   = 2;
  localparam int NPO   = 2;
  localparam int NCOMB = 4;
  localparam int TOTAL = (NCOMB + 2) * NSFF + NCOMB + 4;
  localparam int FL    = NSFF + 4;
  localparam int IW    = $clog2(NCOMB);
  localparam int CW    = $clog2(TOTAL + 1);

  // {pi, ps} per vector
  localparam logic [NPI+NSFF-1:0] STIM [NCOMB] = '{
    6'b01_1010, 6'b10_0111, 6'b11_1100, 6'b00_0001
  };

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, wr_en_i = 1'b0;
  logic [IW-1:0]   wr_idx_i = '0;
  logic [NPI-1:0]  wr_pi_i = '0;
  logic [NSFF-1:0] wr_ps_i = '0, wr_ns_i = '0;
  logic [NPO-1:0]  wr_po_i = '0;
  logic tc_o, sin_o, sout_o, clk_en_o, done_o, fail_o;
  logic [CW-1:0] fail_cyc_o, cyc_cnt_o;
  int n_run = 0, n_fail = 0;
  logic [NSFF-1:0] cm = '0;

  always #10 clk = ~clk;

  scan_seq_top #(.NSFF(NSFF), .NPI(NPI), .NPO(NPO), .NCOMB(NCOMB)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .wr_en_i, .wr_idx_i, .wr_pi_i, .wr_ps_i,
    .wr_po_i, .wr_ns_i, .tc_o, .sin_o, .sout_o, .clk_en_o, .done_o, .fail_o,
    .fail_cyc_o, .cyc_cnt_o
  );

  function automatic logic [NSFF-1:0] ns_f(logic [NSFF-1:0] s, logic [NPI-1:0] p);
    for (int i = 0; i < NSFF; i++) ns_f[i] = s[i] ^ s[(i+1) % NSFF] ^ p[i % NPI];
  endfunction
  function automatic logic [NPO-1:0] po_f(logic [NSFF-1:0] s, logic [NPI-1:0] p);
    for (int j = 0; j < NPO; j++) po_f[j] = s[j % NSFF] & p[j % NPI];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_vec(int v, logic [NPO-1:0] po_x, logic [NSFF-1:0] ns_x);
    logic [NPI-1:0]  p = STIM[v][NSFF +: NPI];
    logic [NSFF-1:0] s = STIM[v][NSFF-1:0];
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = IW'(v); wr_pi_i = p; wr_ps_i = s;
    wr_po_i = po_f(s, p) ^ po_x; wr_ns_i = ns_f(s, p) ^ ns_x;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run_test(bit poke, bit exp_fail, int exp_fcyc);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      int j, v, b;
      j = k - FL; v = (j >= 0) ? j / (NSFF + 1) : 0; b = (j >= 0) ? j % (NSFF + 1) : 0;
      check("R2 clk_en_o high", clk_en_o, 1);
      check("R2 cyc_cnt_o", cyc_cnt_o, k);
      if (k == 0) check("R8 fail cleared at start", fail_o, 0);
      if (k < FL) begin
        check("R4 flush sout_o", sout_o, cm[NSFF-1]);
        if (k >= NSFF) check("R4 flush delay", sout_o, ((k - NSFF) >> 1) & 1);
        check("R3 flush tc_o", tc_o, 0);
        check("R3 flush sin_o", sin_o, (k >> 1) & 1);
      end else if (v < NCOMB) begin
        if (v > 0) check("R6 captured ns at sout_o", sout_o, cm[NSFF-1]);
        if (b < NSFF) begin
          check("R5 shift tc_o", tc_o, 0);
          check("R5 shift sin_o", sin_o, STIM[v][NSFF-1-b]);
        end else check("R5 capture tc_o", tc_o, 1);
      end else begin
        check("R7 unload tc_o", tc_o, 0);
        check("R7 unload sout_o", sout_o, cm[NSFF-1]);
      end
      if (k >= FL && v < NCOMB && b == NSFF) cm = ns_f(cm, STIM[v][NSFF +: NPI]);
      else cm = {cm[NSFF-2:0], sin_o};
      if (poke && k == 10) begin
        start_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = IW'(3);
        wr_pi_i = STIM[3][NSFF +: NPI]; wr_ps_i = STIM[3][NSFF-1:0];
        wr_po_i = ~po_f(STIM[3][NSFF-1:0], STIM[3][NSFF +: NPI]); wr_ns_i = '1;
      end
      if (poke && k == 11) begin start_i = 1'b0; wr_en_i = 1'b0; end
      @(negedge clk);
    end
    check("R9 done_o pulse", done_o, 1);
    check("R9 clk_en_o low at done", clk_en_o, 0);
    check("R9 total cycles", cyc_cnt_o, TOTAL);
    check("R8 fail_o", fail_o, exp_fail);
    if (exp_fail) check("R8 fail_cyc_o", fail_cyc_o, exp_fcyc);
    @(negedge clk);
    check("R9 done_o single cycle", done_o, 0);
    check("R9 count held", cyc_cnt_o, TOTAL);
    check("R11 idle tc_o", tc_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tc_o", tc_o, 1);
    check("R1 clk_en_o", clk_en_o, 0);
    check("R1 done_o", done_o, 0);
    check("R1 fail_o", fail_o, 0);
    check("R1 cyc_cnt_o", cyc_cnt_o, 0);
    check("R1 sout_o", sout_o, 0);
    rst_ni = 1'b1;
    for (int v = 0; v < NCOMB; v++) write_vec(v, '0, '0);
    // R10 and R2: mid-run write and start are ignored, run stays clean
    run_test(1'b1, 1'b0, 0);
    // R8: bad expected po on vector 2 -> capture cycle 8+2*5+4
    write_vec(2, 2'b01, '0);
    run_test(1'b0, 1'b1, 22);
    // R8: first of two errors is kept (vector 0 ns[3] at 13, vector 3 ns[0] at 31)
    write_vec(2, '0, '0);
    write_vec(0, '0, 4'b1000);
    write_vec(3, '0, 4'b0001);
    run_test(1'b0, 1'b1, 13);
    write_vec(0, '0, '0);
    run_test(1'b0, 1'b1, 31);
    write_vec(3, '0, '0);
    // R11: chain holds while idle
    repeat (5) @(negedge clk);
    check("R11 idle clk_en_o", clk_en_o, 0);
    check("R11 idle sout_o held", sout_o, cm[NSFF-1]);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule